// File: doc/BRIEF.md
# Time-Slotted Bus Arbiter with Paged Configuration

This block decides which agent on a shared bus segment owns the bus. Time is cut into repeating frames, and each frame into slots. A slot either belongs to one agent or is left open for contention. When the slot's owner is not asking for the bus, or the slot is open, a fallback policy picks the winner. That policy is either fixed priority or round-robin. A free-running frame counter tells the block where it is in the frame.

All settings can be rewritten while the bus runs: the frame length, where each slot ends, who owns each slot, and the fallback policy. They are held in several pages. A page select chooses which page drives arbitration, and a new selection only takes hold when a frame starts. An agent that holds the bus keeps it for as long as it keeps requesting. The next winner is worked out while that transfer is still in progress, so the bus passes from one agent to the next with no idle cycle. A resync pulse restarts the frame so that it lines up with an application phase.

Top module: `tdma_arbiter`

## Requirements
- R1: While reset is held and just after it, `gnt` is zero, `activePage` is 0 and `frameStart` is 1. Every page resets to a frame length of 16, slot s ending at count 4*(s+1), slot s owned by agent s mod 4, no open slots, and fixed priority.
- R2: The frame count runs from 0 to L-1, where L is the frame length of the active page, and then returns to 0. `frameStart` is 1 exactly when the count is 0. A length of 0 or 1 gives a frame of one cycle.
- R3: The current slot is the lowest-numbered slot whose end value is greater than the frame count. A count that no slot end exceeds falls in an open cycle.
- R4: In an owned slot whose owner requests, the owner wins the next free grant, whatever other agents request.
- R5: In an open slot, or an owned slot whose owner does not request, the fallback policy of the active page picks among the requesting agents.
- R6: With policy 0 (fixed priority), the requesting agent with the lowest index wins.
- R7: With policy 1 (round-robin), the search starts at the agent after the last one granted and wraps around. After reset the last granted agent is taken to be agent 3.
- R8: An agent whose grant is set keeps it in every cycle in which its request stays high. Slot boundaries and frame boundaries do not end the grant.
- R9: A grant is registered, so it appears one cycle after the request that earns it. When the holder drops its request and others are requesting, the new grant appears in the very next cycle.
- R10: A write on the configuration port changes the addressed page from the next cycle. Address 0 holds the frame length. Address 1 holds the policy in bit 0. Address 2+2s holds the end of slot s. Address 3+2s holds the owner of slot s in bits 1:0 and the open flag in bit 2.
- R11: A page selection is stored and becomes `activePage` only when the count returns to 0. A frame therefore never uses two pages.
- R12: A `resync` pulse sets the count to 0 in the next cycle, and the stored page selection takes effect at that point.
- R13: `gnt` is one-hot or zero. A newly set grant goes only to an agent that was requesting. With no requests, `gnt` is zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 4 | One request line per agent |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPage | input | 1 | Page targeted by the configuration write |
| cfgAddr | input | 4 | Configuration field address |
| cfgData | input | 8 | Configuration write value |
| pageWe | input | 1 | Stores a new page selection |
| pageSel | input | 1 | Page to use from the next frame start |
| resync | input | 1 | Restarts the frame |
| gnt | output | 4 | One-hot bus grant |
| activePage | output | 1 | Page currently driving arbitration |
| frameStart | output | 1 | High in the first cycle of a frame |

## Verification
The hardest case to reach from the ports is a page selection that waits through a whole frame and then switches exactly at the wrap. The same goes for a transfer that is held across a slot boundary into a slot owned by another agent. Random traffic seldom lines up with either event. The stimulus therefore uses `resync` to put the count at a known value, shortens the frame on the other page, and then counts cycles up to the boundary. Long random runs then mix configuration rewrites, page swaps and resyncs with requests that persist and release, and they are compared cycle by cycle against a reference model in the bench.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

  // Strobes from the frame control to the arbitration datapath
  typedef struct packed {
    logic frameEnd;   // last cycle of the current frame
    logic restart;    // external phase resync
  } tdmaStrobe_t;

endpackage

// File: rtl/tdma_arb_ctrl.sv
module tdma_arb_ctrl
  import tdma_arb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resync,
  input  logic [CNT_W-1:0] frameLen,
  output tdmaStrobe_t      strobe,
  output logic [CNT_W-1:0] slotCycle,
  output logic             frameStart
);

  logic [CNT_W:0] nextPos;
  logic           atEnd;

  always_comb begin
    nextPos = {1'b0, slotCycle} + (CNT_W+1)'(1);
    atEnd   = nextPos >= {1'b0, frameLen};
    strobe.frameEnd = atEnd;
    strobe.restart  = resync;
    frameStart      = (slotCycle == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCycle <= '0;
    end else if (resync || atEnd) begin
      slotCycle <= '0;
    end else begin
      slotCycle <= nextPos[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/tdma_arb_data.sv
module tdma_arb_data
  import tdma_arb_pkg::*;
#(
  parameter int NUM_AGENTS   = 4,
  parameter int NUM_SLOTS    = 4,
  parameter int NUM_PAGES    = 2,
  parameter int CNT_W        = 8,
  parameter int DEF_SLOT_LEN = 4,
  parameter int AGT_W        = 2,
  parameter int PAGE_W       = 1,
  parameter int ADDR_W       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] req,
  input  logic                  cfgWe,
  input  logic [PAGE_W-1:0]     cfgPage,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [CNT_W-1:0]      cfgData,
  input  logic                  pageWe,
  input  logic [PAGE_W-1:0]     pageSel,
  input  tdmaStrobe_t           strobe,
  input  logic [CNT_W-1:0]      slotCycle,
  output logic [CNT_W-1:0]      frameLen,
  output logic [NUM_AGENTS-1:0] gnt,
  output logic [PAGE_W-1:0]     activePage
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // Paged configuration store
  logic [CNT_W-1:0] frameLenR [NUM_PAGES];
  logic             policyR   [NUM_PAGES];
  logic [CNT_W-1:0] slotEndR  [NUM_PAGES][NUM_SLOTS];
  logic [AGT_W-1:0] slotOwnR  [NUM_PAGES][NUM_SLOTS];
  logic             slotOpenR [NUM_PAGES][NUM_SLOTS];

  logic [PAGE_W-1:0]     curPage, pendPage;
  logic [NUM_AGENTS-1:0] gntR;
  logic [AGT_W-1:0]      rrPtr;

  // Arbitration intermediates
  logic              slotHit;
  logic [SLOT_W-1:0] slotIdx;
  logic [AGT_W-1:0]  ownerId;
  logic              ownerClaims;
  logic              prioValid, rrValid;
  logic [AGT_W-1:0]  prioIdx, rrIdx, cand;
  logic              winValid;
  logic [AGT_W-1:0]  winIdx;
  logic              holderBusy;
  logic              pageSwap;

  always_comb begin
    frameLen = frameLenR[curPage];
    pageSwap = strobe.frameEnd | strobe.restart;

    // Slot lookup: lowest slot whose end lies beyond the count
    slotHit = 1'b0;
    slotIdx = '0;
    for (int s = NUM_SLOTS-1; s >= 0; s--) begin
      if (slotCycle < slotEndR[curPage][s]) begin
        slotHit = 1'b1;
        slotIdx = SLOT_W'(s);
      end
    end
    ownerId     = slotOwnR[curPage][slotIdx];
    ownerClaims = slotHit && !slotOpenR[curPage][slotIdx] && req[ownerId];

    // Fixed priority: lowest index
    prioValid = 1'b0;
    prioIdx   = '0;
    for (int i = NUM_AGENTS-1; i >= 0; i--) begin
      if (req[i]) begin
        prioValid = 1'b1;
        prioIdx   = AGT_W'(i);
      end
    end

    // Round-robin: first requester after the last granted agent
    rrValid = 1'b0;
    rrIdx   = '0;
    cand    = '0;
    for (int k = NUM_AGENTS; k >= 1; k--) begin
      cand = AGT_W'((int'(rrPtr) + k) % NUM_AGENTS);
      if (req[cand]) begin
        rrValid = 1'b1;
        rrIdx   = cand;
      end
    end

    if (ownerClaims) begin
      winValid = 1'b1;
      winIdx   = ownerId;
    end else if (policyR[curPage]) begin
      winValid = rrValid;
      winIdx   = rrIdx;
    end else begin
      winValid = prioValid;
      winIdx   = prioIdx;
    end

    holderBusy = |(gntR & req);
  end

  // Configuration writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        frameLenR[p] <= CNT_W'(NUM_SLOTS * DEF_SLOT_LEN);
        policyR[p]   <= 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
          slotEndR[p][s]  <= CNT_W'((s + 1) * DEF_SLOT_LEN);
          slotOwnR[p][s]  <= AGT_W'(s % NUM_AGENTS);
          slotOpenR[p][s] <= 1'b0;
        end
      end
    end else if (cfgWe) begin
      if (cfgAddr == ADDR_W'(0)) frameLenR[cfgPage] <= cfgData;
      if (cfgAddr == ADDR_W'(1)) policyR[cfgPage]   <= cfgData[0];
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cfgAddr == ADDR_W'(2 + 2*s)) slotEndR[cfgPage][s] <= cfgData;
        if (cfgAddr == ADDR_W'(3 + 2*s)) begin
          slotOwnR[cfgPage][s]  <= cfgData[AGT_W-1:0];
          slotOpenR[cfgPage][s] <= cfgData[AGT_W];
        end
      end
    end
  end

  // Page pointer and grant register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      pendPage <= '0;
      gntR     <= '0;
      rrPtr    <= AGT_W'(NUM_AGENTS - 1);
    end else begin
      if (pageSwap) curPage  <= pendPage;
      if (pageWe)   pendPage <= pageSel;
      if (!holderBusy) begin
        gntR <= winValid ? (NUM_AGENTS'(1) << winIdx) : '0;
        if (winValid) rrPtr <= winIdx;
      end
    end
  end

  assign gnt        = gntR;
  assign activePage = curPage;

endmodule

// File: rtl/tdma_arbiter.sv
module tdma_arbiter
  import tdma_arb_pkg::*;
#(
  parameter int NUM_AGENTS   = 4,
  parameter int NUM_SLOTS    = 4,
  parameter int NUM_PAGES    = 2,
  parameter int CNT_W        = 8,
  parameter int DEF_SLOT_LEN = 4,
  localparam int AGT_W  = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1,
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ADDR_W = $clog2(2 + 2*NUM_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] req,
  input  logic                  cfgWe,
  input  logic [PAGE_W-1:0]     cfgPage,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [CNT_W-1:0]      cfgData,
  input  logic                  pageWe,
  input  logic [PAGE_W-1:0]     pageSel,
  input  logic                  resync,
  output logic [NUM_AGENTS-1:0] gnt,
  output logic [PAGE_W-1:0]     activePage,
  output logic                  frameStart
);

  tdmaStrobe_t      strobe;
  logic [CNT_W-1:0] slotCycle;
  logic [CNT_W-1:0] frameLen;

  tdma_arb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resync     (resync),
    .frameLen   (frameLen),
    .strobe     (strobe),
    .slotCycle  (slotCycle),
    .frameStart (frameStart)
  );

  tdma_arb_data #(
    .NUM_AGENTS   (NUM_AGENTS),
    .NUM_SLOTS    (NUM_SLOTS),
    .NUM_PAGES    (NUM_PAGES),
    .CNT_W        (CNT_W),
    .DEF_SLOT_LEN (DEF_SLOT_LEN),
    .AGT_W        (AGT_W),
    .PAGE_W       (PAGE_W),
    .ADDR_W       (ADDR_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .req        (req),
    .cfgWe      (cfgWe),
    .cfgPage    (cfgPage),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .pageWe     (pageWe),
    .pageSel    (pageSel),
    .strobe     (strobe),
    .slotCycle  (slotCycle),
    .frameLen   (frameLen),
    .gnt        (gnt),
    .activePage (activePage)
  );

endmodule

// File: rtl/tdma_arbiter_chk.sv
module tdma_arbiter_chk #(
  parameter int NUM_AGENTS = 4,
  parameter int PAGE_W     = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_AGENTS-1:0] req,
  input logic [NUM_AGENTS-1:0] gnt,
  input logic [PAGE_W-1:0]     activePage,
  input logic                  frameStart
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_grant_onehot_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));

  assert_new_grant_requested_R13: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ((gnt & ~$past(gnt)) != '0)) |-> ((gnt & $past(req)) != '0));

  assert_idle_clears_R13: assert property (@(posedge clk) disable iff (!rstN)
    (req == '0) |=> (gnt == '0));

  assert_hold_no_preempt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(gnt & req)) |=> (gnt == $past(gnt)));

  assert_handover_gapless_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!(|(gnt & req)) && (|req)) |=> (gnt != '0));

  assert_page_at_frame_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (activePage != $past(activePage))) |-> frameStart);

endmodule

bind tdma_arbiter tdma_arbiter_chk #(
  .NUM_AGENTS (NUM_AGENTS),
  .PAGE_W     (PAGE_W)
) u_chk (.*);

// File: tb/tdma_arbiter_test.sv
`timescale 1ns/1ps
module tdma_arbiter_test;
  localparam int NA = 4;
  localparam int NS = 4;
  localparam int NP = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] req = '0;
  logic       cfgWe = 1'b0;
  logic [0:0] cfgPage = '0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       pageWe = 1'b0;
  logic [0:0] pageSel = '0;
  logic       resync = 1'b0;
  logic [3:0] gnt;
  logic [0:0] activePage;
  logic       frameStart;
  bit         done = 0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tdma_arbiter uut (
    .clk(clk), .rstN(rstN), .req(req), .cfgWe(cfgWe), .cfgPage(cfgPage),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .pageWe(pageWe), .pageSel(pageSel),
    .resync(resync), .gnt(gnt), .activePage(activePage), .frameStart(frameStart)
  );

  // Reference model state
  int    mLen [NP];
  int    mPol [NP];
  int    mEnd [NP][NS];
  int    mOwn [NP][NS];
  bit    mOpen[NP][NS];
  int    mCnt, mPage, mPend, mGnt, mRr;
  string mWhy;

  function automatic void modelReset();
    for (int p = 0; p < NP; p++) begin
      mLen[p] = 16;
      mPol[p] = 0;
      for (int s = 0; s < NS; s++) begin
        mEnd[p][s]  = 4 * (s + 1);
        mOwn[p][s]  = s % NA;
        mOpen[p][s] = 0;
      end
    end
    mCnt = 0; mPage = 0; mPend = 0; mGnt = -1; mRr = NA - 1; mWhy = "R1 reset";
  endfunction

  function automatic void pickWinner(output int w, output string why);
    int slot;
    slot = -1;
    w = -1;
    for (int s = NS-1; s >= 0; s--) if (mCnt < mEnd[mPage][s]) slot = s;
    if (slot >= 0 && !mOpen[mPage][slot] && req[mOwn[mPage][slot]]) begin
      w = mOwn[mPage][slot];
      why = "R4 owned slot, R3 lookup";
      return;
    end
    if (req == 0) begin
      why = "R13 idle";
      return;
    end
    if (mPol[mPage] == 0) begin
      for (int i = NA-1; i >= 0; i--) if (req[i]) w = i;
      why = "R5 R6 fixed priority";
    end else begin
      for (int k = NA; k >= 1; k--) if (req[(mRr + k) % NA]) w = (mRr + k) % NA;
      why = "R5 R7 round robin";
    end
  endfunction

  function automatic void modelStep();
    int    w, a, s;
    string why;
    bit    busy, atEnd;
    busy = (mGnt >= 0) && req[mGnt];
    if (busy) mWhy = "R8 hold";
    else begin
      pickWinner(w, why);
      if (mGnt >= 0 && w >= 0) why = {why, ", R9 handover"};
      mGnt = w;
      if (w >= 0) mRr = w;
      mWhy = why;
    end
    atEnd = (mCnt + 1 >= mLen[mPage]);
    if (resync || atEnd) begin
      mCnt = 0;
      mPage = mPend;
    end else mCnt++;
    if (pageWe) mPend = int'(pageSel);
    if (cfgWe) begin
      a = int'(cfgAddr);
      if (a == 0) mLen[cfgPage] = int'(cfgData);
      else if (a == 1) mPol[cfgPage] = int'(cfgData[0]);
      else if (a < 2 + 2*NS) begin
        s = (a - 2) / 2;
        if ((a % 2) == 0) mEnd[cfgPage][s] = int'(cfgData);
        else begin
          mOwn[cfgPage][s]  = int'(cfgData[1:0]);
          mOpen[cfgPage][s] = cfgData[2];
        end
      end
    end
  endfunction

  function automatic void check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic int hot(int w);
    return (w < 0) ? 0 : (1 << w);
  endfunction

  function automatic int idxOf(logic [3:0] g);
    int r;
    r = -1;
    for (int i = 0; i < NA; i++) if (g[i]) r = i;
    return r;
  endfunction

  // Called at a falling edge with inputs set for the next rising edge
  task automatic tick();
    modelStep();
    @(negedge clk);
    check(mWhy, int'(gnt), hot(mGnt));
    check("R11 active page", int'(activePage), mPage);
    check("R2 frame start", int'(frameStart), int'(mCnt == 0));
    cfgWe = 1'b0;
    pageWe = 1'b0;
    resync = 1'b0;
  endtask

  task automatic cfgW(int page, int addr, int data);
    cfgWe = 1'b1;
    cfgPage = page[0:0];
    cfgAddr = addr[3:0];
    cfgData = data[7:0];
    tick();
  endtask

  initial begin
    int prev;
    logic [3:0] nr;
    void'($urandom(32'd20517));
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset grant", int'(gnt), 0);
    check("R1 reset page", int'(activePage), 0);
    check("R1 reset frame start", int'(frameStart), 1);
    rstN = 1'b1;

    // R10: give slot 0 of page 0 to agent 2, then R4 ownership beats priority
    cfgW(0, 3, 2);
    resync = 1'b1; tick();
    req = 4'b0101; tick();
    check("R10 R4 rewritten owner wins", int'(gnt), 4'b0100);
    repeat (6) tick();
    check("R8 grant held across slot boundary", int'(gnt), 4'b0100);
    req = 4'b0001; tick();
    check("R9 handover next cycle", int'(gnt), 4'b0001);
    req = 4'b0000; tick();
    check("R13 no requests clears grant", int'(gnt), 0);

    // R11: page select waits for frame wrap
    cfgW(1, 0, 5);
    resync = 1'b1; tick();
    pageWe = 1'b1; pageSel = 1'b1; tick();
    check("R11 page held mid frame", int'(activePage), 0);
    repeat (14) tick();
    check("R11 page held in last cycle", int'(activePage), 0);
    tick();
    check("R11 page switches at boundary", int'(activePage), 1);
    check("R2 frame wraps after length", int'(frameStart), 1);

    // R12: resync restarts frame and applies stored page
    pageWe = 1'b1; pageSel = 1'b0; tick();
    check("R12 no switch before resync", int'(activePage), 1);
    resync = 1'b1; tick();
    check("R12 resync restarts frame", int'(frameStart), 1);
    check("R12 resync applies page", int'(activePage), 0);

    // R7: round-robin with every slot open
    cfgW(0, 1, 1);
    for (int s = 0; s < NS; s++) cfgW(0, 3 + 2*s, 4);
    req = 4'b1111; tick();
    for (int n = 0; n < 8; n++) begin
      prev = idxOf(gnt);
      req = 4'b1111 & ~gnt;
      tick();
      check("R7 rotation order", int'(gnt), hot((prev + 1) % NA));
    end

    // R6: fixed priority favours lowest requester
    cfgW(0, 1, 0);
    for (int n = 0; n < 4; n++) begin
      prev = idxOf(gnt);
      req = 4'b1111 & ~gnt;
      tick();
      check("R6 lowest index wins", int'(gnt), (prev == 0) ? 4'b0010 : 4'b0001);
    end
    req = 4'b0000; tick();

    // Random traffic with run-time reconfiguration
    for (int n = 0; n < 5000; n++) begin
      nr = req;
      for (int i = 0; i < NA; i++) begin
        if (gnt[i]) nr[i] = ($urandom % 4) != 0;
        else if (req[i]) nr[i] = ($urandom % 8) != 0;
        else nr[i] = ($urandom % 4) == 0;
      end
      req = nr;
      if (($urandom % 40) == 0) begin
        cfgWe = 1'b1;
        cfgPage = 1'($urandom % 2);
        cfgAddr = 4'($urandom % 10);
        if (cfgAddr == 0) cfgData = 8'(1 + $urandom % 20);
        else if (cfgAddr == 1) cfgData = 8'($urandom % 2);
        else if (cfgAddr[0] == 1'b0) cfgData = 8'($urandom % 24);
        else cfgData = 8'($urandom % 8);
      end
      if (($urandom % 150) == 0) begin
        pageWe = 1'b1;
        pageSel = 1'($urandom % 2);
      end
      if (($urandom % 300) == 0) resync = 1'b1;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule